// File: doc/BRIEF.md
# CPU Mode Sequencer: Reset, Initialization, Pause and Run

This block is the mode and machine-cycle sequencer of a small 8-bit processor. It runs the timing generator, which sets where each machine cycle starts and ends and produces the two timing pulses `tpa` and `tpb`. It also produces the two-bit state code that tells the rest of the core which kind of machine cycle is under way: fetch (00), execute (01), DMA (10) or interrupt (11). Instruction decode, the ALU and the counter/timer are outside the block. The block only reaches them through request inputs and strobe outputs.

Reset is applied synchronously to the internal registers. While `rst` is high, the bus and strobe outputs are also forced combinationally, so they take their reset levels at once, without waiting for a clock edge. Reset is followed by a longer initialization cycle. This cycle emits strobes that save X and P into T, then clear X, P and R0 and set the master interrupt enable. After initialization the block enters either a DMA cycle or a fetch from address zero.

`clk` runs at twice the processor clock rate. Each processor clock is two `clk` periods, and `clk_phase` shows the processor clock level. A pause freezes the cycle step and both timing pulses, while `clk_phase` keeps toggling. A pause can be taken at either pulse, or requested by software at the `tpb` point. Resuming waits for the processor-clock edge of the polarity that matches the pause point.

Top module: `cpu_mode_seq`

## Requirements
- R1: While `rst` is high, and without waiting for a clock edge, the outputs are forced to: `q`=0, `mrd_n`=1, `mwr_n`=1, `tpa`=0, `tpb`=0, `sc`=2'b01, `n`=0, `bus`=0. Outside reset these outputs pass the core's values through, and the timing pulses follow the timing generator.
- R2: `ctl_reset` is high exactly while `rst` is high. It drives the core's reset actions: clear I/N, set both interrupt enables, clear the pending counter interrupt, stop the counter, clear the counter mode and disable Q toggling.
- R3: The first `clk` edge after `rst` falls starts the initialization cycle. Without pauses, this cycle lasts 2*INIT_CLOCKS `clk` edges (18 by default). `init_active` is high and `sc` is 01 for the whole cycle.
- R4: During initialization, `xp_to_t` is high for one `clk` at step COPY_STEP (4). Later, at step CLEAR_STEP (6), `clr_xp_r0` and `mie_set` are high together for one `clk`. Step 0 is the interval before the first edge after reset.
- R5: The cycle that follows initialization is DMA (10) if `dma_req` is high at the final edge, and fetch (00) otherwise. It is never execute or interrupt.
- R6: A normal cycle is 2*CYC_CLOCKS `clk` edges (16). `tpa` is high at steps 2 and 3, and `tpb` is high at steps 13 and 14. Fetch is followed by execute. Execute and DMA are followed by DMA if `dma_req` is high, else by interrupt if `int_req` is high, else by fetch. Interrupt is followed by DMA if `dma_req` is high, else by fetch. Requests are sampled at the cycle's final edge.
- R7: If `wait_n` is low on the edge where `tpa` rises, the block pauses. `paused` goes high. `tpa`, `tpb` and `sc` hold their values and the step stops, while `clk_phase` keeps toggling.
- R8: If `wait_n` is low on the edge where `tpb` rises, the block pauses in the same way, with `tpb` held high.
- R9: A hardware pause ends once `wait_n` is high. A pause at `tpa` advances only on an edge where `clk_phase` goes from 1 to 0. A pause at `tpb` advances only on an edge where `clk_phase` goes from 0 to 1.
- R10: An `idle_req` pulse at any time in a cycle pauses the block at that cycle's `tpb` rise. That pause is not released by `wait_n` alone. It ends only when `dma_req` or `int_req` is high (with `wait_n` high and the R9 edge rule), or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the processor clock rate |
| rst | input | 1 | Active-high reset; synchronous for state, forces outputs at once |
| wait_n | input | 1 | Low requests a hardware pause at the next pulse rise |
| idle_req | input | 1 | Software pause request, taken at the next `tpb` rise |
| dma_req | input | 1 | DMA request; wakes an idle pause |
| int_req | input | 1 | Interrupt request; wakes an idle pause |
| core_q | input | 1 | Q level from the core |
| core_mrd_n | input | 1 | Memory read strobe from the core, active low |
| core_mwr_n | input | 1 | Memory write strobe from the core, active low |
| core_n | input | 3 | I/O select lines from the core |
| core_bus | input | DW | Data bus value from the core |
| q | output | 1 | Q output, 0 in reset |
| mrd_n | output | 1 | Memory read strobe, 1 in reset |
| mwr_n | output | 1 | Memory write strobe, 1 in reset |
| n | output | 3 | I/O select lines, 0 in reset |
| bus | output | DW | Data bus, 0 in reset |
| tpa | output | 1 | First timing pulse |
| tpb | output | 1 | Second timing pulse |
| sc | output | 2 | Machine-cycle state code |
| clk_phase | output | 1 | Processor clock level |
| paused | output | 1 | Timing generator is frozen |
| init_active | output | 1 | Initialization cycle under way |
| ctl_reset | output | 1 | Reset action strobe to the core |
| xp_to_t | output | 1 | Copy X,P into T |
| clr_xp_r0 | output | 1 | Clear X, P and R0 |
| mie_set | output | 1 | Set master interrupt enable |

## Verification
The bench builds the block with its default parameters: an 8-clock cycle, a 9-clock initialization cycle, the pulses at steps 2 and 13, and the strobes at steps 4 and 6. With these values a full normal cycle takes 16 edges and the initialization cycle takes 18. Random runs can therefore cover many cycle-to-cycle transitions, pauses at both pulses with both clock polarities, and idle wake-ups. An odd `tpb` step and an even `tpa` step put the two resume polarities on opposite processor-clock levels, so a wrong polarity shows up as a one-edge slip in the pulses.

// File: rtl/cms_pkg.sv
package cms_pkg;

    typedef enum logic [1:0] {
        SC_FETCH = 2'b00,
        SC_EXEC  = 2'b01,
        SC_DMA   = 2'b10,
        SC_INTR  = 2'b11
    } sc_e;

    // one-hot record of where the timing generator was frozen
    typedef enum logic [1:0] {
        PP_NONE = 2'b00,
        PP_TPA  = 2'b01,
        PP_TPB  = 2'b10
    } pp_e;

    function automatic sc_e pick_next(sc_e cur, logic from_init, logic dma, logic intr);
        sc_e nxt;
        if (from_init) begin
            nxt = dma ? SC_DMA : SC_FETCH;
        end else begin
            unique case (cur)
                SC_FETCH: nxt = SC_EXEC;
                SC_INTR:  nxt = dma ? SC_DMA : SC_FETCH;
                default:  nxt = dma ? SC_DMA : (intr ? SC_INTR : SC_FETCH);
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/cms_timing.sv
module cms_timing
    import cms_pkg::*;
#(
    parameter int CYC_CLOCKS  = 8,
    parameter int INIT_CLOCKS = 9,
    parameter int TPA_STEP    = 2,
    parameter int TPB_STEP    = 13,
    localparam int CYC_STEPS  = 2 * CYC_CLOCKS,
    localparam int INIT_STEPS = 2 * INIT_CLOCKS,
    localparam int MAX_STEPS  = (CYC_STEPS > INIT_STEPS) ? CYC_STEPS : INIT_STEPS,
    localparam int PW         = $clog2(MAX_STEPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_init,
    input  logic          wait_n,
    input  logic          idle_req,
    input  logic          wake,
    output logic [PW-1:0] ph,
    output logic          cyc_end,
    output logic          tpa_o,
    output logic          tpb_o,
    output logic          phase_o,
    output logic          paused_o
);

    logic [PW-1:0] ph_q, ph_nx, last;
    logic          phase_q, paused_q, sw_q, pend_q;
    pp_e           pt_q;
    logic          adv, rel, pend_in, at_end, edge_ok;

    always_comb begin
        last    = in_init ? PW'(INIT_STEPS - 1) : PW'(CYC_STEPS - 1);
        at_end  = (ph_q == last);
        ph_nx   = at_end ? '0 : ph_q + 1'b1;
        // a pulse-A freeze leaves on a falling processor clock, a pulse-B freeze on a rising one
        edge_ok = (pt_q == PP_TPA) ? phase_q : !phase_q;
        rel     = wait_n && (!sw_q || wake) && edge_ok;
        adv     = !paused_q || rel;
        pend_in = pend_q | idle_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= '0;
            phase_q  <= 1'b1;
            paused_q <= 1'b0;
            sw_q     <= 1'b0;
            pend_q   <= 1'b0;
            pt_q     <= PP_NONE;
        end else begin
            phase_q <= !phase_q;
            pend_q  <= pend_in;
            if (adv) begin
                ph_q     <= ph_nx;
                paused_q <= 1'b0;
                sw_q     <= 1'b0;
                pt_q     <= PP_NONE;
                if (ph_nx == PW'(TPA_STEP) && !wait_n) begin
                    paused_q <= 1'b1;
                    pt_q     <= PP_TPA;
                end
                if (ph_nx == PW'(TPB_STEP) && (!wait_n || pend_in)) begin
                    paused_q <= 1'b1;
                    pt_q     <= PP_TPB;
                    sw_q     <= pend_in;
                    pend_q   <= 1'b0;
                end
            end
        end
    end

    assign ph       = ph_q;
    assign cyc_end  = adv && at_end;
    assign phase_o  = phase_q;
    assign paused_o = paused_q;
    assign tpa_o    = (ph_q == PW'(TPA_STEP)) || (ph_q == PW'(TPA_STEP + 1));
    assign tpb_o    = (ph_q == PW'(TPB_STEP)) || (ph_q == PW'(TPB_STEP + 1));

endmodule

// File: rtl/cms_cycle.sv
module cms_cycle
    import cms_pkg::*;
#(
    parameter int PW         = 5,
    parameter int COPY_STEP  = 4,
    parameter int CLEAR_STEP = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc_end,
    input  logic [PW-1:0] ph,
    input  logic          dma_req,
    input  logic          int_req,
    output sc_e           sc_o,
    output logic          in_init,
    output logic          copy_stb,
    output logic          clear_stb
);

    sc_e  sc_q;
    logic init_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_q   <= SC_EXEC;
            init_q <= 1'b1;
        end else if (cyc_end) begin
            sc_q   <= pick_next(sc_q, init_q, dma_req, int_req);
            init_q <= 1'b0;
        end
    end

    assign sc_o      = sc_q;
    assign in_init   = init_q;
    assign copy_stb  = init_q && (ph == PW'(COPY_STEP));
    assign clear_stb = init_q && (ph == PW'(CLEAR_STEP));

endmodule

// File: rtl/cpu_mode_seq.sv
module cpu_mode_seq
    import cms_pkg::*;
#(
    parameter int DW          = 8,
    parameter int CYC_CLOCKS  = 8,
    parameter int INIT_CLOCKS = 9,
    parameter int TPA_STEP    = 2,
    parameter int TPB_STEP    = 13,
    parameter int COPY_STEP   = 4,
    parameter int CLEAR_STEP  = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wait_n,
    input  logic          idle_req,
    input  logic          dma_req,
    input  logic          int_req,
    input  logic          core_q,
    input  logic          core_mrd_n,
    input  logic          core_mwr_n,
    input  logic [2:0]    core_n,
    input  logic [DW-1:0] core_bus,
    output logic          q,
    output logic          mrd_n,
    output logic          mwr_n,
    output logic [2:0]    n,
    output logic [DW-1:0] bus,
    output logic          tpa,
    output logic          tpb,
    output logic [1:0]    sc,
    output logic          clk_phase,
    output logic          paused,
    output logic          init_active,
    output logic          ctl_reset,
    output logic          xp_to_t,
    output logic          clr_xp_r0,
    output logic          mie_set
);

    localparam int MAX_STEPS = 2 * ((CYC_CLOCKS > INIT_CLOCKS) ? CYC_CLOCKS : INIT_CLOCKS);
    localparam int PW        = $clog2(MAX_STEPS);

    logic [PW-1:0] ph;
    logic          cyc_end, t_tpa, t_tpb, in_init, copy_stb, clear_stb;
    sc_e           sc_q;

    cms_timing #(
        .CYC_CLOCKS (CYC_CLOCKS),
        .INIT_CLOCKS(INIT_CLOCKS),
        .TPA_STEP   (TPA_STEP),
        .TPB_STEP   (TPB_STEP)
    ) u_timing (
        .clk     (clk),
        .rst     (rst),
        .in_init (in_init),
        .wait_n  (wait_n),
        .idle_req(idle_req),
        .wake    (dma_req | int_req),
        .ph      (ph),
        .cyc_end (cyc_end),
        .tpa_o   (t_tpa),
        .tpb_o   (t_tpb),
        .phase_o (clk_phase),
        .paused_o(paused)
    );

    cms_cycle #(
        .PW        (PW),
        .COPY_STEP (COPY_STEP),
        .CLEAR_STEP(CLEAR_STEP)
    ) u_cycle (
        .clk      (clk),
        .rst      (rst),
        .cyc_end  (cyc_end),
        .ph       (ph),
        .dma_req  (dma_req),
        .int_req  (int_req),
        .sc_o     (sc_q),
        .in_init  (in_init),
        .copy_stb (copy_stb),
        .clear_stb(clear_stb)
    );

    // reset levels reach the pins combinationally, ahead of any clock edge
    always_comb begin
        q           = rst ? 1'b0 : core_q;
        mrd_n       = rst | core_mrd_n;
        mwr_n       = rst | core_mwr_n;
        n           = rst ? 3'b000 : core_n;
        bus         = rst ? '0 : core_bus;
        tpa         = !rst && t_tpa;
        tpb         = !rst && t_tpb;
        sc          = rst ? SC_EXEC : sc_q;
        ctl_reset   = rst;
        init_active = !rst && in_init;
        xp_to_t     = !rst && copy_stb;
        clr_xp_r0   = !rst && clear_stb;
        mie_set     = !rst && clear_stb;
    end

endmodule

// File: rtl/cms_checker.sv
module cms_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          q,
    input logic          mrd_n,
    input logic          mwr_n,
    input logic [2:0]    n,
    input logic [DW-1:0] bus,
    input logic          tpa,
    input logic          tpb,
    input logic [1:0]    sc,
    input logic          paused,
    input logic          init_active,
    input logic          xp_to_t,
    input logic          clr_xp_r0
);

    logic seen_copy;

    always_ff @(posedge clk) begin
        if (rst)               seen_copy <= 1'b0;
        else if (xp_to_t)      seen_copy <= 1'b1;
        else if (!init_active) seen_copy <= 1'b0;
    end

    always @(posedge clk) begin
        if (rst === 1'b1) begin
            assert_reset_levels_R1: assert (q == 1'b0 && mrd_n && mwr_n && !tpa && !tpb
                                            && sc == 2'b01 && n == 3'b000 && bus == '0);
        end
    end

    assert_init_exec_R3: assert property (@(posedge clk) disable iff (rst)
        init_active |-> sc == 2'b01);

    assert_copy_first_R4: assert property (@(posedge clk) disable iff (rst)
        clr_xp_r0 |-> seen_copy);

    assert_copy_in_init_R4: assert property (@(posedge clk) disable iff (rst)
        xp_to_t |-> init_active);

    assert_after_init_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(init_active) |-> (sc == 2'b00 || sc == 2'b10));

    assert_pulses_apart_R6: assert property (@(posedge clk) disable iff (rst)
        !(tpa && tpb));

    assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (paused && $past(paused)) |-> ($stable(tpa) && $stable(tpb) && $stable(sc)));

    assert_paused_on_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        paused |-> (tpa || tpb));

endmodule

bind cpu_mode_seq cms_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .q          (q),
    .mrd_n      (mrd_n),
    .mwr_n      (mwr_n),
    .n          (n),
    .bus        (bus),
    .tpa        (tpa),
    .tpb        (tpb),
    .sc         (sc),
    .paused     (paused),
    .init_active(init_active),
    .xp_to_t    (xp_to_t),
    .clr_xp_r0  (clr_xp_r0)
);

// File: tb/cpu_mode_seq_test.sv
`timescale 1ns/100ps
module cpu_mode_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wait_n = 1'b1, idle_req = 1'b0, dma_req = 1'b0, int_req = 1'b0;
    logic       core_q = 1'b1, core_mrd_n = 1'b0, core_mwr_n = 1'b0;
    logic [2:0] core_n = 3'b101;
    logic [7:0] core_bus = 8'hA5;
    logic       q, mrd_n, mwr_n, tpa, tpb, clk_phase, paused;
    logic       init_active, ctl_reset, xp_to_t, clr_xp_r0, mie_set;
    logic [2:0] n;
    logic [7:0] bus;
    logic [1:0] sc;

    int checks = 0, errors = 0, cycles = 0;
    bit cmp_on = 1'b0, done = 1'b0;

    // reference model state
    int   m_ph, m_pt;
    bit   m_osc, m_paused, m_sw, m_pend, m_init;
    logic [1:0] m_sc;

    always #2.5 clk = ~clk;

    cpu_mode_seq uut (
        .clk(clk), .rst(rst), .wait_n(wait_n), .idle_req(idle_req), .dma_req(dma_req),
        .int_req(int_req), .core_q(core_q), .core_mrd_n(core_mrd_n), .core_mwr_n(core_mwr_n),
        .core_n(core_n), .core_bus(core_bus), .q(q), .mrd_n(mrd_n), .mwr_n(mwr_n), .n(n),
        .bus(bus), .tpa(tpa), .tpb(tpb), .sc(sc), .clk_phase(clk_phase), .paused(paused),
        .init_active(init_active), .ctl_reset(ctl_reset), .xp_to_t(xp_to_t),
        .clr_xp_r0(clr_xp_r0), .mie_set(mie_set)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_next(logic [1:0] cur, bit init, bit dma, bit intr);
        if (init)                   return dma ? 2'b10 : 2'b00;
        if (cur == 2'b00)           return 2'b01;
        if (dma)                    return 2'b10;
        if (intr && cur != 2'b11)   return 2'b11;
        return 2'b00;
    endfunction

    // cycle-accurate model, advanced from the inputs seen at each edge
    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_osc = 1; m_paused = 0; m_sw = 0; m_pend = 0;
            m_init = 1; m_sc = 2'b01; m_pt = 0;
        end else begin
            bit go, last_step, pend_in, right_edge;
            int nph;
            last_step  = (m_ph == (m_init ? 17 : 15));
            right_edge = (m_pt == 1) ? m_osc : !m_osc;
            go = !m_paused || (wait_n && (!m_sw || dma_req || int_req) && right_edge);
            pend_in = m_pend | idle_req;
            m_pend  = pend_in;
            m_osc   = !m_osc;
            if (go) begin
                nph = last_step ? 0 : m_ph + 1;
                m_paused = 0; m_sw = 0; m_pt = 0;
                if (nph == 2 && !wait_n) begin m_paused = 1; m_pt = 1; end
                if (nph == 13 && (!wait_n || pend_in)) begin
                    m_paused = 1; m_pt = 2; m_sw = pend_in; m_pend = 0;
                end
                if (last_step) begin
                    m_sc = exp_next(m_sc, m_init, dma_req, int_req);
                    m_init = 0;
                end
                m_ph = nph;
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (cmp_on && !done) begin
            check("R6/R9 tpa", tpa, !rst && (m_ph == 2 || m_ph == 3));
            check("R6/R9 tpb", tpb, !rst && (m_ph == 13 || m_ph == 14));
            check("R5/R6 sc", sc, rst ? 1 : m_sc);
            check("R7/R8/R10 paused", paused, m_paused);
            check("R7 clk_phase", clk_phase, m_osc);
            check("R3 init_active", init_active, !rst && m_init);
            check("R4 xp_to_t", xp_to_t, !rst && m_init && m_ph == 4);
            check("R4 clr_xp_r0", clr_xp_r0, !rst && m_init && m_ph == 6);
            check("R4 mie_set", mie_set, !rst && m_init && m_ph == 6);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #1;
        // R1 and R2: reset levels, immediately and without an edge
        check("R1 q", q, 0);
        check("R1 mrd_n", mrd_n, 1);
        check("R1 mwr_n", mwr_n, 1);
        check("R1 n", n, 0);
        check("R1 bus", bus, 0);
        check("R2 ctl_reset", ctl_reset, 1);
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        rst = 1'b0;
        #0.5;
        check("R1 pass q", q, 1);
        check("R1 pass bus", bus, 8'hA5);
        check("R2 ctl_reset low", ctl_reset, 0);
        // R3/R5: DMA held through initialization
        dma_req = 1'b1;
        edges(17);
        check("R3 init still active at edge 17", init_active, 1);
        check("R3 sc exec in init", sc, 1);
        edges(1);
        check("R3 init over at edge 18", init_active, 0);
        check("R5 dma after init", sc, 2'b10);
        @(negedge clk);
        dma_req = 1'b0;
        // R1: reset forced mid-cycle, checked before any edge
        repeat (5) @(negedge clk);
        rst = 1'b1;
        #0.5;
        check("R1 async mrd_n", mrd_n, 1);
        check("R1 async sc", sc, 1);
        check("R1 async q", q, 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R10: idle pause, wait_n alone does not release
        edges(20);
        @(negedge clk);
        idle_req = 1'b1;
        @(negedge clk);
        idle_req = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (paused) break;
        end
        check("R10 idle paused", paused, 1);
        check("R10 paused at tpb", tpb, 1);
        repeat (20) @(negedge clk);
        check("R10 wait_n alone keeps pause", paused, 1);
        int_req = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 int_req wakes", paused, 0);
        int_req = 1'b0;
        // random traffic with directed reset bursts
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            wait_n   = ($urandom_range(99) >= 12);
            idle_req = ($urandom_range(99) < 2);
            dma_req  = ($urandom_range(99) < 10);
            int_req  = ($urandom_range(99) < 10);
            core_q   = $urandom_range(1);
            core_bus = 8'($urandom);
            rst      = ($urandom_range(999) < 3);
        end
        @(negedge clk);
        rst = 1'b0;
        edges(2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule